// File: doc/BRIEF.md
# Serial Converter Link Host Controller

This block drives a serial successive-approximation converter from the host side. It generates the converter clock by dividing the system clock, and it runs one frame for each accepted request. In a frame it lowers the active-low select, sends a five-bit multiplexer address, and waits for the converter's busy status to go high and then low. It then reads an eleven-bit two's-complement result, sign first and most significant bit first, and returns the result sign-extended to sixteen bits.

Requests arrive on a valid/ready port. `req_ready` is high only while the controller is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high, and the channel, mode and power-down fields are captured in that cycle. The result port has no back-pressure: `res_valid` is a single-cycle strobe, and `res_data` holds its value until the next strobe. A power-down request sends an address with the power bit cleared and ends the frame without converting. The conversion that follows reset, and the conversion that follows a power-down frame, are treated as warm-up conversions and give no result.

Top module: `sar_link_host`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `adc_cs_n` is 1, `adc_sck` is 0, `req_ready` is 1, and `res_valid` and `conv_timeout` are 0.
- R2: `adc_sck` toggles every `sck_half_div`+1 system clocks, giving equal high and low times. The programmed value must be 3 or more.
- R3: The address goes out on `adc_di` in this order: power bit (1 = run, 0 = power down), mode bit (1 = single-ended, 0 = differential), then `req_chan[0]`, `req_chan[2]`, `req_chan[1]`. Bits are sampled on five successive rising edges of `adc_sck`. `adc_di` changes only while `adc_sck` falls, and `adc_cs_n` falls together with a falling edge of `adc_sck`.
- R4: `req_ready` is high only in the idle state and stays low for the whole time `adc_cs_n` is low.
- R5: After the address, busy is sampled on rising edges of `adc_sck` through a two-flop synchronizer. The first rising edge that sees busy low, after busy was seen high, captures the sign bit from `adc_do`.
- R6: The sign bit and ten magnitude bits are captured on eleven consecutive rising edges, most significant first. `res_data` is that value sign-extended to 16 bits, and `res_valid` is high for exactly one cycle.
- R7: If no busy fall is seen within 16 rising edges after the address, `conv_timeout` pulses for one cycle, `adc_cs_n` rises on that 16th edge, and no result is given.
- R8: `adc_cs_n` stays high for at least 5 rising edges of `adc_sck` before each falling edge of `adc_cs_n`, including the first one after reset.
- R9: The first completed conversion after reset, and the first after a power-down frame, give no `res_valid`.
- R10: A power-down request sends the address with the power bit at 0. `adc_cs_n` rises at the falling edge after the fifth address bit, without waiting for busy, and no result is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_half_div | input | DIVW | Half-period of the converter clock, in system clocks, minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_chan | input | 3 | Channel number |
| req_diff | input | 1 | 1 = differential pair, 0 = single-ended |
| req_pdown | input | 1 | 1 = send a power-down address |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | OUT_W | Sign-extended conversion result |
| conv_timeout | output | 1 | One-cycle pulse when the busy fall is not seen in time |
| adc_sck | output | 1 | Converter clock |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_di | output | 1 | Serial address to the converter |
| adc_busy | input | 1 | Converter busy status, asynchronous |
| adc_do | input | 1 | Converter serial data, asynchronous |

## Verification
The checks assume a converter that changes `adc_busy` and `adc_do` only at falling edges of `adc_sck`. They also assume `sck_half_div` is at least 3, so that the two-flop synchronizer settles within half a converter clock. The bench's converter model updates its outputs only on falling clock edges. The bench changes the divider only between frames and never programs a value below 3. The clock-period assertion allows a change of the divider by skipping the check across that interval.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

  localparam int ADDR_BITS = 5;
  localparam int CHAN_W    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_ADDR,
    ST_TAIL,
    ST_WAIT,
    ST_DATA
  } host_st_e;

  // power bit, mode bit, odd bit, then the two pair-select bits
  function automatic logic [ADDR_BITS-1:0] build_addr(
      input logic              pdown,
      input logic              diff,
      input logic [CHAN_W-1:0] chan);
    return {~pdown, ~diff, chan[0], chan[2], chan[1]};
  endfunction

endpackage

// File: rtl/sar_link_sck.sv
module sar_link_sck #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] half_div,
  output logic            sck,
  output logic            rise_tick,
  output logic            fall_tick
);
  logic [DIVW-1:0] cnt;
  logic            wrap;

  assign wrap      = (cnt >= half_div);
  assign rise_tick = wrap & ~sck;
  assign fall_tick = wrap &  sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_link_sync.sv
module sar_link_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_link_rx.sv
module sar_link_rx #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [OUT_W-1:0] ext_next
);
  localparam int EXT_W = OUT_W - IN_W;

  logic [IN_W-1:0] sr;
  logic [IN_W-1:0] nxt;

  assign nxt      = {sr[IN_W-2:0], din};
  assign ext_next = {{EXT_W{nxt[IN_W-1]}}, nxt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= nxt;
  end
endmodule

// File: rtl/sar_link_host.sv
module sar_link_host
  import sar_link_pkg::*;
#(
  parameter int DIVW    = 8,
  parameter int GAP_SCK = 5,
  parameter int TMO_SCK = 16,
  parameter int RES_W   = 11,
  parameter int OUT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIVW-1:0]  sck_half_div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_chan,
  input  logic             req_diff,
  input  logic             req_pdown,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_data,
  output logic             conv_timeout,
  output logic             adc_sck,
  output logic             adc_cs_n,
  output logic             adc_di,
  input  logic             adc_busy,
  input  logic             adc_do
);
  localparam int GAP_W = $clog2(GAP_SCK + 1);
  localparam int TMO_W = $clog2(TMO_SCK + 1);
  localparam int BIT_W = $clog2(RES_W + ADDR_BITS + 1);

  host_st_e             state;
  logic                 rise_tick, fall_tick;
  logic                 busy_s, do_s;
  logic [ADDR_BITS-1:0] addr_sr;
  logic                 pd_q;
  logic [BIT_W-1:0]     bitcnt;
  logic [GAP_W-1:0]     gapcnt;
  logic [TMO_W-1:0]     tmocnt;
  logic                 busy_seen;
  logic                 need_flush;
  logic                 cs_n_q, di_q;
  logic                 res_valid_q, tmo_q;
  logic [OUT_W-1:0]     res_data_q;
  logic [OUT_W-1:0]     ext_next;
  logic                 gap_ok;
  logic                 busy_fall;
  logic                 shift_en;

  sar_link_sck #(.DIVW(DIVW)) u_sck (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_div  (sck_half_div),
    .sck       (adc_sck),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  sar_link_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({adc_busy, adc_do}),
    .q     ({busy_s, do_s})
  );

  assign busy_fall = busy_seen & ~busy_s;
  assign shift_en  = rise_tick &
                     (((state == ST_WAIT) & busy_fall) | (state == ST_DATA));

  sar_link_rx #(.IN_W(RES_W), .OUT_W(OUT_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (do_s),
    .ext_next (ext_next)
  );

  assign gap_ok = (gapcnt >= GAP_W'(GAP_SCK));

  // converter clocks seen while select is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gapcnt <= '0;
    else if (!cs_n_q)           gapcnt <= '0;
    else if (rise_tick && !gap_ok) gapcnt <= gapcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      addr_sr     <= '0;
      pd_q        <= 1'b0;
      bitcnt      <= '0;
      tmocnt      <= '0;
      busy_seen   <= 1'b0;
      need_flush  <= 1'b1;
      cs_n_q      <= 1'b1;
      di_q        <= 1'b0;
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
      tmo_q       <= 1'b0;
    end else begin
      res_valid_q <= 1'b0;
      tmo_q       <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_sr <= build_addr(req_pdown, req_diff, req_chan);
            pd_q    <= req_pdown;
            state   <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (fall_tick && gap_ok) begin
            cs_n_q  <= 1'b0;
            di_q    <= addr_sr[ADDR_BITS-1];
            addr_sr <= {addr_sr[ADDR_BITS-2:0], 1'b0};
            bitcnt  <= '0;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (rise_tick) begin
            if (bitcnt == BIT_W'(ADDR_BITS - 1)) begin
              bitcnt    <= '0;
              tmocnt    <= '0;
              busy_seen <= 1'b0;
              state     <= pd_q ? ST_TAIL : ST_WAIT;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end else if (fall_tick) begin
            di_q    <= addr_sr[ADDR_BITS-1];
            addr_sr <= {addr_sr[ADDR_BITS-2:0], 1'b0};
          end
        end
        ST_TAIL: begin
          if (fall_tick) begin
            di_q       <= 1'b0;
            cs_n_q     <= 1'b1;
            need_flush <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (fall_tick) di_q <= 1'b0;
          if (rise_tick) begin
            if (busy_fall) begin
              bitcnt <= BIT_W'(1);
              state  <= ST_DATA;
            end else begin
              busy_seen <= busy_seen | busy_s;
              if (tmocnt == TMO_W'(TMO_SCK - 1)) begin
                tmo_q  <= 1'b1;
                cs_n_q <= 1'b1;
                state  <= ST_IDLE;
              end else begin
                tmocnt <= tmocnt + 1'b1;
              end
            end
          end
        end
        ST_DATA: begin
          if (rise_tick) begin
            if (bitcnt == BIT_W'(RES_W - 1)) begin
              cs_n_q <= 1'b1;
              state  <= ST_IDLE;
              if (need_flush) begin
                need_flush <= 1'b0;
              end else begin
                res_valid_q <= 1'b1;
                res_data_q  <= ext_next;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign res_valid    = res_valid_q;
  assign res_data     = res_data_q;
  assign conv_timeout = tmo_q;
  assign adc_cs_n     = cs_n_q;
  assign adc_di       = di_q;
endmodule

// File: rtl/sar_link_host_chk.sv
module sar_link_host_chk #(
  parameter int DIVW    = 8,
  parameter int GAP_SCK = 5,
  parameter int RES_W   = 11,
  parameter int OUT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIVW-1:0]  sck_half_div,
  input logic             req_ready,
  input logic             res_valid,
  input logic [OUT_W-1:0] res_data,
  input logic             conv_timeout,
  input logic             adc_sck,
  input logic             adc_cs_n,
  input logic             adc_di
);
  localparam int EXT_N = OUT_W - RES_W + 1;

  logic            sck_d;
  logic [7:0]      hi_rises;
  logic [DIVW:0]   run;
  logic            div_chg;
  logic [DIVW-1:0] div_d;
  logic            toggled;

  assign toggled = (adc_sck != sck_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      hi_rises <= '0;
      run      <= '0;
      div_chg  <= 1'b1;
      div_d    <= '0;
    end else begin
      sck_d <= adc_sck;
      div_d <= sck_half_div;
      if (!adc_cs_n) hi_rises <= '0;
      else if (adc_sck && !sck_d && hi_rises != 8'hff) hi_rises <= hi_rises + 1'b1;
      if (toggled) begin
        run     <= '0;
        div_chg <= 1'b0;
      end else begin
        run <= run + 1'b1;
        if (sck_half_div != div_d) div_chg <= 1'b1;
      end
    end
  end

  p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (toggled && !div_chg && sck_half_div == div_d) |-> (run == {1'b0, sck_half_div}));

  p_cs_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !adc_sck);

  p_di_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $rose(adc_sck)) |-> $stable(adc_di));

  p_busy_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> !req_ready);

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_data[OUT_W-1:RES_W-1]) == 0 ||
                   $countones(res_data[OUT_W-1:RES_W-1]) == EXT_N));

  p_tmo_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_timeout |-> (adc_cs_n && !res_valid));

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_rises >= 8'(GAP_SCK)));
endmodule

bind sar_link_host sar_link_host_chk #(
  .DIVW(DIVW), .GAP_SCK(GAP_SCK), .RES_W(RES_W), .OUT_W(OUT_W)
) u_chk (.*);

// File: tb/tb_sar_link_host.sv
module tb_sar_link_host;
  localparam int DIVW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [DIVW-1:0] sck_half_div = 8'd3;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [2:0]      req_chan = '0;
  logic            req_diff = 1'b0;
  logic            req_pdown = 1'b0;
  logic            res_valid;
  logic [15:0]     res_data;
  logic            conv_timeout;
  logic            adc_sck, adc_cs_n, adc_di;
  logic            adc_busy = 1'b0;
  logic            adc_do = 1'b0;

  always #10 clk = ~clk;

  sar_link_host dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  localparam int CONV = 10;
  int          v [8];
  int          mode = 0;          // 0 normal, 1 busy never rises, 2 busy stuck high
  logic [4:0]  m_addr, last_addr;
  int          m_nrx = 0, m_stage = 0, m_cnt = 0, m_bit = 0;
  logic [10:0] m_code;
  int          pd_seen = 0;

  function automatic int model_code(input logic [4:0] a);
    int ch;
    ch = {a[1], a[0], a[2]};
    if (a[3]) return v[ch];
    return v[ch] - v[ch ^ 1];
  endfunction

  always @(posedge adc_sck or negedge adc_sck or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      m_nrx = 0; m_stage = 0;
      adc_busy <= 1'b0;
    end else if (adc_sck) begin
      if (m_nrx < 5) begin
        m_addr = {m_addr[3:0], adc_di};
        m_nrx++;
        if (m_nrx == 5) begin
          last_addr = m_addr;
          if (m_addr[4]) m_stage = 1;
          else pd_seen++;
        end
      end
    end else begin
      case (m_stage)
        1: begin
          if (mode != 1) adc_busy <= 1'b1;
          m_cnt = 0; m_code = 11'(model_code(m_addr)); m_stage = 2;
        end
        2: if (mode == 0) begin
          m_cnt++;
          if (m_cnt == CONV) begin
            adc_busy <= 1'b0; adc_do <= m_code[10]; m_bit = 9; m_stage = 3;
          end
        end
        3: if (m_bit >= 0) begin
          adc_do <= m_code[m_bit]; m_bit--;
        end
        default: ;
      endcase
    end
  end

  // ---------------- monitors (sampled on falling clk) ----------------
  int          res_cnt = 0, tmo_cnt = 0;
  logic [15:0] last_res = '0;
  logic        p_sck = 1'b0, p_cs = 1'b1;
  int          hi_rises = 0, min_gap = 1000, frame_rises = 0, ready_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin res_cnt++; last_res = res_data; end
      if (conv_timeout) tmo_cnt++;
      if (!adc_cs_n && req_ready) ready_bad++;
      if (p_cs && !adc_cs_n) begin
        if (hi_rises < min_gap) min_gap = hi_rises;
        frame_rises = 0;
      end
      if (adc_cs_n) begin
        if (!p_cs) hi_rises = 0;
        if (adc_sck && !p_sck) hi_rises++;
      end else if (adc_sck && !p_sck) frame_rises++;
      p_sck = adc_sck; p_cs = adc_cs_n;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic conv(input logic [2:0] ch, input logic diff, input logic pd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_chan = ch; req_diff = diff; req_pdown = pd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (adc_cs_n) @(negedge clk);
    while (!adc_cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [4:0] exp_addr(input logic [2:0] ch, input logic diff, input logic pd);
    return {~pd, ~diff, ch[0], ch[2], ch[1]};
  endfunction

  task automatic conv_chk(input logic [2:0] ch, input logic diff);
    int rc, code;
    rc = res_cnt;
    conv(ch, diff, 1'b0);
    code = diff ? v[ch] - v[ch ^ 1] : v[ch];
    chk(res_cnt == rc + 1, "R6 one strobe", res_cnt - rc, 1);
    chk(last_res == 16'(code), "R5 R6 result", last_res, 16'(code));
    chk(last_addr == exp_addr(ch, diff, 1'b0), "R3 address", last_addr, exp_addr(ch, diff, 1'b0));
  endtask

  task automatic duty(input int d);
    int hi, lo;
    hi = 0; lo = 0;
    @(negedge clk);
    while (!(adc_sck && !p_sck)) @(negedge clk);
    while (adc_sck) begin hi++; @(negedge clk); end
    while (!adc_sck) begin lo++; @(negedge clk); end
    chk(hi == d + 1, "R2 high time", hi, d + 1);
    chk(lo == d + 1, "R2 low time", lo, d + 1);
  endtask

  initial begin
    int rc, tc, pc;
    int divs [3] = '{3, 5, 8};
    for (int i = 0; i < 8; i++) v[i] = 0;
    repeat (4) @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sck == 1'b0, "R1 pins in reset", {adc_cs_n, adc_sck}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 select high", adc_cs_n, 1);
    chk(adc_sck == 1'b0, "R1 clock low", adc_sck, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(res_valid == 1'b0 && conv_timeout == 1'b0, "R1 strobes idle", {res_valid, conv_timeout}, 0);

    duty(3);

    // warm-up conversion after reset
    v[0] = 100;
    rc = res_cnt;
    conv(3'd0, 1'b0, 1'b0);
    chk(res_cnt == rc, "R9 first after reset dropped", res_cnt - rc, 0);
    chk(last_addr == exp_addr(3'd0, 1'b0, 1'b0), "R3 address warm-up", last_addr, exp_addr(3'd0, 1'b0, 1'b0));

    // sweep: divider x mode x channel
    for (int k = 0; k < 3; k++) begin
      sck_half_div = 8'(divs[k]);
      duty(divs[k]);
      for (int i = 0; i < 8; i++) v[i] = ((i * 173 + k * 389) % 1024) - 512;
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 8; c++) conv_chk(3'(c), 1'(d));
    end

    // range corners
    sck_half_div = 8'd3;
    v[0] = 1023; v[1] = -1024;
    conv_chk(3'd0, 1'b0);
    conv_chk(3'd1, 1'b0);
    v[0] = 511; v[1] = -512;
    conv_chk(3'd0, 1'b1);
    conv_chk(3'd1, 1'b1);
    v[6] = 0; v[7] = 0;
    conv_chk(3'd7, 1'b1);

    // power-down frame
    rc = res_cnt; pc = pd_seen;
    conv(3'd2, 1'b0, 1'b1);
    chk(pd_seen == pc + 1, "R10 power bit cleared", pd_seen - pc, 1);
    chk(last_addr[4] == 1'b0, "R10 address power bit", last_addr[4], 0);
    chk(frame_rises == 5, "R10 frame ends after address", frame_rises, 5);
    chk(res_cnt == rc, "R10 no result", res_cnt - rc, 0);
    conv(3'd2, 1'b0, 1'b0);
    chk(res_cnt == rc, "R9 first after power-down dropped", res_cnt - rc, 0);
    conv_chk(3'd2, 1'b0);

    // busy never rises, then busy stuck high
    for (int m = 1; m <= 2; m++) begin
      mode = m;
      rc = res_cnt; tc = tmo_cnt;
      conv(3'd4, 1'b0, 1'b0);
      chk(tmo_cnt == tc + 1, "R7 timeout pulse", tmo_cnt - tc, 1);
      chk(res_cnt == rc, "R7 no result", res_cnt - rc, 0);
      chk(frame_rises == 20, "R7 window length", frame_rises, 20);
    end
    mode = 0;
    conv_chk(3'd4, 1'b0);

    chk(min_gap >= 5, "R8 select-high gap", min_gap, 5);
    chk(ready_bad == 0, "R4 ready low in frame", ready_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule